// File: doc/BRIEF.md
# Programmable Register Write Sequencer

This block keeps a table of register-write steps and replays them on command, so that a long bring-up routine for a set of control registers can be launched with a single start strobe. Every step names a target register, a data value, a bit position and a field width. Playing a step reads the target register, replaces only the chosen bit-field and writes the result back. After a step, the block can wait a programmable number of timebase ticks before it continues. A step flagged as final ends the run.

A host fills the table one entry at a time through a programming port, then pulses `start` with the table index where playback should begin. An `abort` ends a run early. `busy` is high while a run is in progress, and `done_irq` pulses for one clock when a run ends. At reset, the first four entries hold a built-in start-up routine. Every other entry holds a harmless one-step routine.

Top module: `wr_sequencer`

## Requirements
- R1: While reset is applied and on the first clock after it, `busy`, `done_irq` and `rf_we` are all low.
- R2: A `start` sampled while idle sets `busy` on the next clock. Playback begins at entry `start_idx`: its address appears on `rf_addr` one clock later, and its write (`rf_we` high) appears on the clock after that. Two consecutive steps without delay produce writes exactly 2 clocks apart.
- R3: Each write is read-modify-write. The register value on `rf_rd_data` is kept in every bit outside the selected field.
- R4: The field starts at bit `lsb` (0..15) and has `width`+1 bits (width code 0 gives 1 bit, 7 gives 8 bits). It takes the low bits of the data value. Field bits above bit 15 are dropped.
- R5: A delay code d (0..15) other than 0 holds playback after the write until 2^d ticks have occurred. One tick occurs every PRESCALE clocks, counted from reset. With code d, two successive writes are between (2^d−1)·PRESCALE+3 and 2^d·PRESCALE+2 clocks apart. Code 0 adds no wait.
- R6: A step with its final flag set ends the run after its write and any delay that follows it. `busy` then falls and no further write occurs.
- R7: `abort` sampled while busy clears `busy` on the next clock. No write of the interrupted step or of any later step happens.
- R8: `done_irq` is high for exactly the clock in which `busy` has just fallen, whether the run ended through the final flag or through an abort.
- R9: A `start` sampled while busy is ignored. The running sequence continues unchanged.
- R10: After entry DEPTH−1, playback continues at entry 0.
- R11: Reset loads these entries (address, data, lsb, width code, delay code, final): 0 = (0x04, 0x1F, 0, 4, 0, 0); 1 = (0x05, 0x03, 1, 1, 1, 0); 2 = (0x0C, 0x07, 14, 2, 0, 0); 3 = (0x04, 0xA5, 8, 7, 0, 1). Every other entry is all zero with the final flag set.
- R12: A `prog_we` pulse stores the `prog_*` fields into entry `prog_idx`. A later run uses the stored fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Store one table entry |
| prog_idx | input | IDX_W | Entry index to store |
| prog_addr | input | 8 | Target register address |
| prog_data | input | 8 | Field data value |
| prog_lsb | input | 4 | Field LSB position |
| prog_width | input | 3 | Field width code (bits = code+1) |
| prog_delay | input | 4 | Post-write delay code |
| prog_last | input | 1 | Final-step flag |
| start | input | 1 | Start strobe |
| start_idx | input | IDX_W | First entry to play |
| abort | input | 1 | Stop a running sequence |
| rf_addr | output | 8 | Register file address (read and write) |
| rf_rd_data | input | 16 | Register file read data for rf_addr |
| rf_we | output | 1 | Register file write strobe |
| rf_wdata | output | 16 | Register file write data |
| busy | output | 1 | Sequence running |
| done_irq | output | 1 | One-clock pulse as busy falls |

## Verification
The assertions assume that the register file returns the word at `rf_addr` on `rf_rd_data` in the same clock, with no wait. They also assume that `start` and `abort` are single-clock strobes driven between clock edges. The bench provides the register file as a zero-latency array and pulses the strobes for one clock at a time, away from the active edge. It never reprograms the table while a run is in progress. Playback behaviour is therefore fixed entirely by the table contents seen at the start of the run.

// File: rtl/wr_seq_pkg.sv
package wr_seq_pkg;
  localparam int ADDR_W  = 8;
  localparam int FIELD_W = 8;
  localparam int REG_W   = 16;
  localparam int LSB_W   = 4;
  localparam int WID_W   = 3;
  localparam int DLY_W   = 4;
  localparam int WCNT_W  = 2 ** DLY_W;
  localparam int NUM_DEFAULT = 4;

  typedef struct packed {
    logic [ADDR_W-1:0]  addr;
    logic [FIELD_W-1:0] data;
    logic [LSB_W-1:0]   lsb;
    logic [WID_W-1:0]   width;
    logic [DLY_W-1:0]   delay;
    logic               last;
  } step_t;

  // Built-in start-up routine; any other entry is a single no-op final step.
  function automatic step_t boot_step(int i);
    step_t s;
    s = '0;
    case (i)
      0: begin s.addr = 8'h04; s.data = 8'h1F; s.lsb = 4'd0;  s.width = 3'd4; end
      1: begin s.addr = 8'h05; s.data = 8'h03; s.lsb = 4'd1;  s.width = 3'd1; s.delay = 4'd1; end
      2: begin s.addr = 8'h0C; s.data = 8'h07; s.lsb = 4'd14; s.width = 3'd2; end
      3: begin s.addr = 8'h04; s.data = 8'hA5; s.lsb = 4'd8;  s.width = 3'd7; s.last = 1'b1; end
      default: s.last = 1'b1;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/seq_step_table.sv
module seq_step_table
  import wr_seq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  step_t            wr_step,
  input  logic [IDX_W-1:0] rd_idx,
  output step_t            rd_step
);
  step_t tbl [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= boot_step(i);
    end else if (wr_en) begin
      tbl[wr_idx] <= wr_step;
    end
  end

  assign rd_step = tbl[rd_idx];
endmodule

// File: rtl/seq_field_merge.sv
module seq_field_merge
  import wr_seq_pkg::*;
(
  input  logic [REG_W-1:0]   old_word,
  input  logic [FIELD_W-1:0] data,
  input  logic [LSB_W-1:0]   lsb,
  input  logic [WID_W-1:0]   width,
  output logic [REG_W-1:0]   new_word
);
  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    logic [LSB_W:0] pos, off;
    logic           sel;
    assign pos = (LSB_W+1)'(b);
    assign off = pos - {1'b0, lsb};
    assign sel = (pos >= {1'b0, lsb}) && (off <= (LSB_W+1)'(width));
    assign new_word[b] = sel ? data[off[WID_W-1:0]] : old_word[b];
  end
endmodule

// File: rtl/seq_timebase.sv
module seq_timebase #(
  parameter int PRESCALE = 4,
  localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  logic [PS_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || cnt == PS_W'(PRESCALE - 1)) cnt <= '0;
    else                                   cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == PS_W'(PRESCALE - 1));
endmodule

// File: rtl/wr_sequencer.sv
module wr_sequencer
  import wr_seq_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int PRESCALE = 4,
  localparam int IDX_W   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               prog_we,
  input  logic [IDX_W-1:0]   prog_idx,
  input  logic [ADDR_W-1:0]  prog_addr,
  input  logic [FIELD_W-1:0] prog_data,
  input  logic [LSB_W-1:0]   prog_lsb,
  input  logic [WID_W-1:0]   prog_width,
  input  logic [DLY_W-1:0]   prog_delay,
  input  logic               prog_last,
  input  logic               start,
  input  logic [IDX_W-1:0]   start_idx,
  input  logic               abort,
  output logic [ADDR_W-1:0]  rf_addr,
  input  logic [REG_W-1:0]   rf_rd_data,
  output logic               rf_we,
  output logic [REG_W-1:0]   rf_wdata,
  output logic               busy,
  output logic               done_irq
);
  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_MERGE, S_WAIT} state_t;

  state_t            state;
  logic [IDX_W-1:0]  idx;
  logic [WCNT_W-1:0] wcnt;
  step_t             cur, new_step;
  logic [REG_W-1:0]  merged;
  logic              tick;

  assign new_step = '{addr: prog_addr, data: prog_data, lsb: prog_lsb,
                      width: prog_width, delay: prog_delay, last: prog_last};

  seq_step_table #(.DEPTH(DEPTH)) u_table (
    .clk(clk), .rst(rst), .wr_en(prog_we), .wr_idx(prog_idx),
    .wr_step(new_step), .rd_idx(idx), .rd_step(cur)
  );

  seq_field_merge u_merge (
    .old_word(rf_rd_data), .data(cur.data), .lsb(cur.lsb),
    .width(cur.width), .new_word(merged)
  );

  seq_timebase #(.PRESCALE(PRESCALE)) u_tb (.clk(clk), .rst(rst), .tick(tick));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      idx      <= '0;
      wcnt     <= '0;
      busy     <= 1'b0;
      done_irq <= 1'b0;
      rf_we    <= 1'b0;
      rf_addr  <= '0;
      rf_wdata <= '0;
    end else begin
      done_irq <= 1'b0;
      rf_we    <= 1'b0;
      if (busy && abort) begin
        state    <= S_IDLE;
        busy     <= 1'b0;
        done_irq <= 1'b1;
      end else begin
        case (state)
          S_IDLE: if (start) begin
            idx   <= start_idx;
            busy  <= 1'b1;
            state <= S_FETCH;
          end
          S_FETCH: begin
            rf_addr <= cur.addr;
            state   <= S_MERGE;
          end
          S_MERGE: begin
            rf_we    <= 1'b1;
            rf_wdata <= merged;
            if (cur.delay != '0) begin
              wcnt  <= WCNT_W'(1) << cur.delay;
              state <= S_WAIT;
            end else if (cur.last) begin
              state    <= S_IDLE;
              busy     <= 1'b0;
              done_irq <= 1'b1;
            end else begin
              idx   <= idx + 1'b1;
              state <= S_FETCH;
            end
          end
          S_WAIT: if (tick) begin
            if (wcnt == WCNT_W'(1)) begin
              if (cur.last) begin
                state    <= S_IDLE;
                busy     <= 1'b0;
                done_irq <= 1'b1;
              end else begin
                idx   <= idx + 1'b1;
                state <= S_FETCH;
              end
            end else begin
              wcnt <= wcnt - 1'b1;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/wr_sequencer_chk.sv
module wr_sequencer_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic abort,
  input logic busy,
  input logic done_irq,
  input logic rf_we
);
  p_irq_on_fall_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done_irq);
  p_irq_needs_fall_r8: assert property (@(posedge clk) disable iff (rst)
    done_irq |-> $fell(busy));
  p_abort_stops_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && abort) |=> (!busy && !rf_we));
  p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy);
  p_write_spacing_r2: assert property (@(posedge clk) disable iff (rst)
    rf_we |=> !rf_we);
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> !rf_we);
endmodule

bind wr_sequencer wr_sequencer_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .abort(abort),
  .busy(busy), .done_irq(done_irq), .rf_we(rf_we)
);

// File: tb/wr_sequencer_tb.sv
module wr_sequencer_tb;
  localparam int DEPTH = 64;
  localparam int P     = 4;

  logic clk = 0, rst = 1;
  logic prog_we = 0, prog_last = 0, start = 0, abort = 0;
  logic [5:0] prog_idx = 0, start_idx = 0;
  logic [7:0] prog_addr = 0, prog_data = 0;
  logic [3:0] prog_lsb = 0, prog_delay = 0;
  logic [2:0] prog_width = 0;
  logic [7:0] rf_addr;
  logic [15:0] rf_rd_data, rf_wdata;
  logic rf_we, busy, done_irq;

  logic [15:0] rf_mem [256];
  int checks = 0, errors = 0, cyc = 0, irq_cnt = 0;
  int we_times [$];

  always #5 clk = ~clk;

  wr_sequencer #(.DEPTH(DEPTH), .PRESCALE(P)) u_dut (
    .clk(clk), .rst(rst), .prog_we(prog_we), .prog_idx(prog_idx),
    .prog_addr(prog_addr), .prog_data(prog_data), .prog_lsb(prog_lsb),
    .prog_width(prog_width), .prog_delay(prog_delay), .prog_last(prog_last),
    .start(start), .start_idx(start_idx), .abort(abort),
    .rf_addr(rf_addr), .rf_rd_data(rf_rd_data), .rf_we(rf_we),
    .rf_wdata(rf_wdata), .busy(busy), .done_irq(done_irq)
  );

  assign rf_rd_data = rf_mem[rf_addr];

  always @(posedge clk) begin
    if (rst) for (int i = 0; i < 256; i++) rf_mem[i] <= 16'h5A5A;
    else if (rf_we) rf_mem[rf_addr] <= rf_wdata;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // ---------------- behavioural reference model ----------------
  int t_addr[DEPTH], t_data[DEPTH], t_lsb[DEPTH], t_w[DEPTH], t_d[DEPTH], t_last[DEPTH];
  logic [15:0] m_mem [256];
  int m_phase, m_idx, m_left, m_pre;
  bit e_busy, e_irq, e_we;
  logic [15:0] e_wdata;
  int e_addr;

  function automatic logic [15:0] field_put(logic [15:0] old, int data, int lsb, int w);
    longint mask;
    mask = ((64'd1 << (w + 1)) - 1) << lsb;
    return 16'((longint'(old) & ~mask) | ((longint'(data) << lsb) & mask));
  endfunction

  task automatic m_defaults();
    for (int i = 0; i < DEPTH; i++) begin
      t_addr[i] = 0; t_data[i] = 0; t_lsb[i] = 0; t_w[i] = 0; t_d[i] = 0; t_last[i] = 1;
    end
    t_addr[0] = 'h04; t_data[0] = 'h1F; t_lsb[0] = 0;  t_w[0] = 4; t_last[0] = 0;
    t_addr[1] = 'h05; t_data[1] = 'h03; t_lsb[1] = 1;  t_w[1] = 1; t_d[1] = 1; t_last[1] = 0;
    t_addr[2] = 'h0C; t_data[2] = 'h07; t_lsb[2] = 14; t_w[2] = 2; t_last[2] = 0;
    t_addr[3] = 'h04; t_data[3] = 'hA5; t_lsb[3] = 8;  t_w[3] = 7; t_last[3] = 1;
  endtask

  task automatic m_step_done();
    if (t_last[m_idx] != 0) begin
      m_phase = 0; e_busy = 0; e_irq = 1;
    end else begin
      m_idx = (m_idx + 1) % DEPTH; m_phase = 1;
    end
  endtask

  always @(posedge clk) begin
    bit tk;
    if (rst) begin
      m_defaults();
      for (int i = 0; i < 256; i++) m_mem[i] = 16'h5A5A;
      m_phase = 0; m_idx = 0; m_left = 0; m_pre = 0;
      e_busy = 0; e_irq = 0; e_we = 0; e_wdata = 0; e_addr = 0;
    end else begin
      tk = (m_pre == P - 1);
      m_pre = (m_pre + 1) % P;
      e_irq = 0; e_we = 0;
      if (e_busy && abort) begin
        m_phase = 0; e_busy = 0; e_irq = 1;
      end else begin
        case (m_phase)
          0: if (start) begin m_idx = start_idx; e_busy = 1; m_phase = 1; end
          1: begin e_addr = t_addr[m_idx]; m_phase = 2; end
          2: begin
            e_we = 1;
            e_wdata = field_put(m_mem[e_addr], t_data[m_idx], t_lsb[m_idx], t_w[m_idx]);
            m_mem[e_addr] = e_wdata;
            if (t_d[m_idx] != 0) begin m_left = 1 << t_d[m_idx]; m_phase = 3; end
            else m_step_done();
          end
          default: if (tk) begin
            if (m_left == 1) m_step_done();
            else m_left--;
          end
        endcase
      end
      if (prog_we) begin
        t_addr[prog_idx] = prog_addr; t_data[prog_idx] = prog_data;
        t_lsb[prog_idx] = prog_lsb; t_w[prog_idx] = prog_width;
        t_d[prog_idx] = prog_delay; t_last[prog_idx] = prog_last;
      end
    end
  end

  // per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(busy == e_busy, "R6", "busy vs model", busy, e_busy);
      chk(done_irq == e_irq, "R8", "done_irq vs model", done_irq, e_irq);
      chk(rf_we == e_we, "R2", "rf_we vs model", rf_we, e_we);
      if (e_we) begin
        chk(rf_wdata == e_wdata, "R3", "rf_wdata vs model", rf_wdata, e_wdata);
        chk(rf_addr == 8'(e_addr), "R12", "rf_addr vs model", rf_addr, e_addr);
      end
      if (rf_we) we_times.push_back(cyc);
      if (done_irq) irq_cnt++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      summary();
    end
  end

  // ---------------- stimulus ----------------
  task automatic prog(int i, int a, int d, int l, int w, int dl, int last);
    @(negedge clk);
    prog_we = 1; prog_idx = 6'(i); prog_addr = 8'(a); prog_data = 8'(d);
    prog_lsb = 4'(l); prog_width = 3'(w); prog_delay = 4'(dl); prog_last = 1'(last);
    @(negedge clk);
    prog_we = 0;
  endtask

  task automatic kick(int i);
    @(negedge clk);
    start = 1; start_idx = 6'(i);
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_writes(int n);
    while (we_times.size() < n) @(negedge clk);
  endtask

  initial begin
    int g;
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    chk(!busy && !done_irq && !rf_we, "R1", "outputs in reset", {busy, done_irq, rf_we}, 0);
    rst = 0;
    @(negedge clk);
    chk(!busy && !done_irq && !rf_we, "R1", "outputs after reset", {busy, done_irq, rf_we}, 0);

    // R11: built-in routine from entry 0
    we_times.delete(); irq_cnt = 0;
    kick(0);
    chk(busy == 1, "R2", "busy after start", busy, 1);
    wait_idle();
    chk(rf_mem[8'h04] == 16'hA55F, "R11", "reg04 after boot", rf_mem[8'h04], 16'hA55F);
    chk(rf_mem[8'h05] == 16'h5A5E, "R3", "reg05 bits kept", rf_mem[8'h05], 16'h5A5E);
    chk(rf_mem[8'h0C] == 16'hDA5A, "R4", "reg0C clipped field", rf_mem[8'h0C], 16'hDA5A);
    chk(we_times.size() == 4, "R6", "boot write count", we_times.size(), 4);
    chk(irq_cnt == 1, "R8", "irq pulses after boot", irq_cnt, 1);

    // R12: programmed sequence at entries 10..12
    prog(10, 'h20, 'h03, 6, 1, 0, 0);
    prog(11, 'h20, 'h01, 15, 0, 2, 0);
    prog(12, 'h21, 'hFF, 4, 3, 0, 1);
    we_times.delete();
    kick(10);
    wait_idle();
    chk(we_times.size() == 3, "R6", "programmed write count", we_times.size(), 3);
    chk(we_times[1] - we_times[0] == 2, "R2", "no-delay spacing", we_times[1] - we_times[0], 2);
    g = we_times[2] - we_times[1];
    chk(g >= 3 * P + 3 && g <= 4 * P + 2, "R5", "delay code 2 spacing", g, 4 * P);
    chk(rf_mem[8'h20] == 16'hDADA, "R12", "reg20 fields", rf_mem[8'h20], 16'hDADA);
    chk(rf_mem[8'h21] == 16'h5AFA, "R4", "reg21 4-bit field", rf_mem[8'h21], 16'h5AFA);

    // R9: start while busy is ignored
    we_times.delete();
    kick(10);
    wait_writes(2);
    kick(0);
    wait_idle();
    chk(we_times.size() == 3, "R9", "restart ignored", we_times.size(), 3);

    // R7: abort during the wait after step 11
    prog(12, 'h21, 'h00, 4, 3, 0, 1);
    we_times.delete(); irq_cnt = 0;
    kick(10);
    wait_writes(2);
    abort = 1;
    @(negedge clk);
    abort = 0;
    chk(busy == 0, "R7", "busy after abort", busy, 0);
    chk(done_irq == 1, "R8", "irq on abort", done_irq, 1);
    repeat (30) @(negedge clk);
    chk(we_times.size() == 2, "R7", "no write after abort", we_times.size(), 2);
    chk(rf_mem[8'h21] == 16'h5AFA, "R7", "reg21 untouched", rf_mem[8'h21], 16'h5AFA);
    chk(irq_cnt == 1, "R8", "single irq on abort", irq_cnt, 1);

    // R10: wrap from last entry to entry 0
    prog(63, 'h30, 'h01, 0, 0, 0, 0);
    we_times.delete();
    kick(63);
    wait_idle();
    chk(we_times.size() == 5, "R10", "wrap write count", we_times.size(), 5);
    chk(rf_mem[8'h30] == 16'h5A5B, "R10", "reg30 bit0", rf_mem[8'h30], 16'h5A5B);

    // R11: untouched entry is a one-step final no-op
    we_times.delete();
    kick(40);
    wait_idle();
    chk(we_times.size() == 1, "R11", "default entry count", we_times.size(), 1);
    chk(rf_mem[8'h00] == 16'h5A5A, "R11", "reg00 unchanged", rf_mem[8'h00], 16'h5A5A);

    summary();
  end
endmodule